// File: doc/BRIEF.md
# Shared-Datapath Integer ALU

This block is a 32-bit integer arithmetic and logic unit in which every operation runs on one of three shared units: a single adder, a single sign-filling right shifter, and a single bitwise logic unit. Subtraction and both compare families run on the adder by choosing what is fed into it. Left shifts and logical right shifts run on the one right shifter by reversing bits and by choosing the fill bit. The unit returns one registered 32-bit result per clock.

The unit has two operands and an operation code. An extra flag marks the compare forms whose operands arrive swapped. In these forms the immediate is on `opnd_a` and the register value is on `opnd_b`, and the question asked is "register < immediate". The unit answers it with a carry-in-free add of the immediate and the inverted register value, so no second adder is needed. The result register is cleared by a synchronous active-high reset.

Top module: `alu_shared`

## Requirements
- R1: `alu_out` is registered: it shows the result for the inputs present at a rising edge of `clk` from that edge on. While `rst` is high at a rising edge, `alu_out` becomes 0.
- R2: Operation code 0 (add) gives `opnd_a + opnd_b` modulo 2^32.
- R3: Operation code 1 (subtract) gives `opnd_a - opnd_b` modulo 2^32.
- R4: With `cmp_swap` low, code 2 (signed less-than) and code 3 (unsigned less-than) give 32'd1 when `opnd_a < opnd_b` and 32'd0 otherwise, comparing as two's complement or as unsigned numbers.
- R5: With `cmp_swap` high, codes 2 and 3 give 32'd1 when `opnd_b < opnd_a` (register below immediate) and 32'd0 otherwise, signed for code 2 and unsigned for code 3. This includes the equal case and the extreme values.
- R6: Code 4 (shift left) shifts `opnd_a` left by `opnd_b[4:0]` with zeros entering. Bits 31..5 of `opnd_b` have no effect.
- R7: Code 5 (logical shift right) shifts `opnd_a` right by `opnd_b[4:0]` with zeros entering at the top.
- R8: Code 6 (arithmetic shift right) shifts `opnd_a` right by `opnd_b[4:0]` with copies of `opnd_a[31]` entering at the top.
- R9: Codes 7, 8, 9 and 10 give the bitwise AND, OR, XOR and NOR of the two operands.
- R10: `cmp_swap` has no effect on any code other than 2 and 3.
- R11: Codes 11 to 15 are unused and give 32'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| opnd_a | input | 32 | First operand (the immediate in the swapped compare forms) |
| opnd_b | input | 32 | Second operand; bits 4..0 are the shift amount |
| op_code | input | 4 | Operation select, encoded as listed in the requirements |
| cmp_swap | input | 1 | Selects the swapped immediate compare for codes 2 and 3 |
| alu_out | output | 32 | Registered result |

## Verification
The assertions assume that `op_code`, `opnd_a`, `opnd_b` and `cmp_swap` are known, two-state values at every rising edge after reset. Each assertion compares `alu_out` with the inputs sampled on the edge before. Some properties are guarded by `!$past(rst)`, so they never read inputs from the cycle before reset was first applied. The bench holds every input at a defined value from time zero. It changes inputs only on falling edges. It keeps `rst` high through the first edges, so every sampled input is settled and two-state.

// File: rtl/alu_shared_pkg.sv
package alu_shared_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLT  = 4'd2,
    OP_SLTU = 4'd3,
    OP_SLL  = 4'd4,
    OP_SRL  = 4'd5,
    OP_SRA  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_NOR  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LU_AND = 2'd0,
    LU_OR  = 2'd1,
    LU_XOR = 2'd2,
    LU_NOR = 2'd3
  } lu_fn_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] add_x,
  input  logic [W-1:0] add_y,
  input  logic         add_cin,
  output logic [W-1:0] add_sum,
  output logic         add_cout,
  output logic         add_ovf
);
  localparam int WX = W + 1;

  logic [WX-1:0] full;

  always_comb begin
    full     = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
    add_sum  = full[W-1:0];
    add_cout = full[W];
    add_ovf  = (add_x[W-1] == add_y[W-1]) && (full[W-1] != add_x[W-1]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  sh_in,
  input  logic [SW-1:0] sh_amt,
  input  logic          sh_left,
  input  logic          sh_fill,
  output logic [W-1:0]  sh_out
);
  localparam int WX = W + 1;

  logic [W-1:0]         in_rev;
  logic [W-1:0]         core_in;
  logic signed [WX-1:0] ext;
  logic signed [WX-1:0] shifted;
  logic [W-1:0]         core_out;
  logic [W-1:0]         out_rev;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rev
      assign in_rev[gi]  = sh_in[W-1-gi];
      assign out_rev[gi] = core_out[W-1-gi];
    end
  endgenerate

  always_comb begin
    core_in  = sh_left ? in_rev : sh_in;
    ext      = $signed({sh_fill, core_in});
    shifted  = ext >>> sh_amt;
    core_out = shifted[W-1:0];
    sh_out   = sh_left ? out_rev : core_out;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_shared_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] lu_a,
  input  logic [W-1:0] lu_b,
  input  lu_fn_e       lu_fn,
  output logic [W-1:0] lu_out
);
  always_comb begin
    unique case (lu_fn)
      LU_AND:  lu_out = lu_a & lu_b;
      LU_OR:   lu_out = lu_a | lu_b;
      LU_XOR:  lu_out = lu_a ^ lu_b;
      default: lu_out = ~(lu_a | lu_b);
    endcase
  end
endmodule

// File: rtl/alu_shared.sv
module alu_shared
  import alu_shared_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   op_code,
  input  logic         cmp_swap,
  output logic [W-1:0] alu_out
);
  alu_op_e       op;
  logic          is_cmp;
  logic [W-1:0]  add_y;
  logic          add_cin;
  logic [W-1:0]  add_sum;
  logic          add_cout;
  logic          add_ovf;
  logic          lt_u;
  logic          lt_s;
  logic [W-1:0]  cmp_word;
  logic          sh_left;
  logic          sh_fill;
  logic [W-1:0]  sh_out;
  lu_fn_e        lu_fn;
  logic [W-1:0]  lu_out;
  logic [W-1:0]  nxt;

  always_comb begin
    op      = alu_op_e'(op_code);
    is_cmp  = (op == OP_SLT) || (op == OP_SLTU);
    add_y   = (op == OP_ADD) ? opnd_b : ~opnd_b;
    add_cin = (op == OP_SUB) || (is_cmp && !cmp_swap);
    // register form: a + ~b + 1, no carry means a < b
    // swapped form:  a + ~b + 0, carry means imm > reg
    lt_u    = cmp_swap ? add_cout : ~add_cout;
    lt_s    = cmp_swap ? ~(add_sum[W-1] ^ add_ovf) : (add_sum[W-1] ^ add_ovf);
    cmp_word = {{(W-1){1'b0}}, (op == OP_SLT) ? lt_s : lt_u};
    sh_left = (op == OP_SLL);
    sh_fill = (op == OP_SRA) ? opnd_a[W-1] : 1'b0;
    unique case (op)
      OP_OR:   lu_fn = LU_OR;
      OP_XOR:  lu_fn = LU_XOR;
      OP_NOR:  lu_fn = LU_NOR;
      default: lu_fn = LU_AND;
    endcase
  end

  alu_adder #(.W(W)) u_adder (
    .add_x   (opnd_a),
    .add_y   (add_y),
    .add_cin (add_cin),
    .add_sum (add_sum),
    .add_cout(add_cout),
    .add_ovf (add_ovf)
  );

  alu_shifter #(.W(W), .SW(SW)) u_shifter (
    .sh_in  (opnd_a),
    .sh_amt (opnd_b[SW-1:0]),
    .sh_left(sh_left),
    .sh_fill(sh_fill),
    .sh_out (sh_out)
  );

  alu_logic #(.W(W)) u_logic (
    .lu_a  (opnd_a),
    .lu_b  (opnd_b),
    .lu_fn (lu_fn),
    .lu_out(lu_out)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                  nxt = add_sum;
      OP_SLT, OP_SLTU:                 nxt = cmp_word;
      OP_SLL, OP_SRL, OP_SRA:          nxt = sh_out;
      OP_AND, OP_OR, OP_XOR, OP_NOR:   nxt = lu_out;
      default:                         nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) alu_out <= '0;
    else     alu_out <= nxt;
  end

  // R1: reset clears the result register
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> alu_out == '0);

  assert_add_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd0) |-> alu_out == $past(opnd_a + opnd_b));

  assert_sub_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd1) |-> alu_out == $past(opnd_a - opnd_b));

  // R4 and R5: compare results are one bit wide
  assert_cmp_bool_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == 4'd2 || $past(op_code) == 4'd3))
      |-> alu_out[W-1:1] == '0);

  assert_sltu_swap_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd3 && $past(cmp_swap))
      |-> alu_out[0] == $past(opnd_b < opnd_a));

  assert_sra_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd6 && $past(opnd_b[SW-1:0]) == '0)
      |-> alu_out == $past(opnd_a));

  assert_nor_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 4'd10) |-> alu_out == ~$past(opnd_a | opnd_b));

  assert_unused_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) > 4'd10) |-> alu_out == '0);
endmodule

// File: tb/test_alu_shared.sv
module test_alu_shared;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [3:0]   op_code = 4'd0;
  logic         cmp_swap = 1'b0;
  logic [W-1:0] alu_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_shared i_alu_shared (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_code(op_code), .cmp_swap(cmp_swap), .alu_out(alu_out)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [3:0] op, logic sw);
    int sh;
    sh = int'(b[4:0]);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return sw ? {31'd0, $signed(b) < $signed(a)} : {31'd0, $signed(a) < $signed(b)};
      4'd3:  return sw ? {31'd0, b < a} : {31'd0, a < b};
      4'd4:  return a << sh;
      4'd5:  return a >> sh;
      4'd6:  return W'($signed(a) >>> sh);
      4'd7:  return a & b;
      4'd8:  return a | b;
      4'd9:  return a ^ b;
      4'd10: return ~(a | b);
      default: return '0;
    endcase
  endfunction

  task automatic expect_out(logic [W-1:0] exp, string tag);
    checks++;
    if (alu_out !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, alu_out, exp);
    end
  endtask

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] op,
                        logic sw, logic [W-1:0] exp, string tag);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_code = op; cmp_swap = sw;
    @(posedge clk);
    #1;
    expect_out(exp, tag);
  endtask

  task automatic test_reset;
    @(negedge clk);
    opnd_a = 32'h1234_5678; opnd_b = 32'h1; op_code = 4'd0; rst = 1'b1;
    @(posedge clk); #1;
    expect_out('0, "R1 reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    expect_out(32'h1234_5679, "R1 latency");
  endtask

  task automatic test_add_sub;
    run_op(32'hFFFF_FFFF, 32'h1, 4'd0, 0, 32'h0, "R2 wrap");
    run_op(32'h7FFF_FFFF, 32'h1, 4'd0, 0, 32'h8000_0000, "R2 ovf");
    run_op(32'd0, 32'd1, 4'd1, 0, 32'hFFFF_FFFF, "R3 borrow");
    run_op(32'd100, 32'd58, 4'd1, 0, 32'd42, "R3 plain");
  endtask

  task automatic test_cmp_reg;
    run_op(32'hFFFF_FFFF, 32'h1, 4'd2, 0, 32'd1, "R4 slt neg");
    run_op(32'hFFFF_FFFF, 32'h1, 4'd3, 0, 32'd0, "R4 sltu big");
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 32'd2 == 0 ? 4'd0 : 4'd2, 0, 32'd1, "R4 slt extreme");
    run_op(32'd7, 32'd7, 4'd3, 0, 32'd0, "R4 sltu equal");
    run_op(32'd7, 32'd7, 4'd2, 0, 32'd0, "R4 slt equal");
  endtask

  task automatic test_cmp_imm;
    run_op(32'd5, 32'd4, 4'd3, 1, 32'd1, "R5 sltiu below");
    run_op(32'd4, 32'd4, 4'd3, 1, 32'd0, "R5 sltiu equal");
    run_op(32'd0, 32'hFFFF_FFFF, 4'd3, 1, 32'd0, "R5 sltiu max reg");
    run_op(32'hFFFF_FFFF, 32'd0, 4'd3, 1, 32'd1, "R5 sltiu max imm");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFE, 4'd2, 1, 32'd1, "R5 slti neg");
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 4'd2, 1, 32'd1, "R5 slti extreme");
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 4'd2, 1, 32'd0, "R5 slti extreme rev");
    run_op(32'd3, 32'd3, 4'd2, 1, 32'd0, "R5 slti equal");
  endtask

  task automatic test_shifts;
    run_op(32'h0000_0001, 32'd31, 4'd4, 0, 32'h8000_0000, "R6 sll 31");
    run_op(32'h8000_00F1, 32'hFFFF_FFE4, 4'd4, 0, 32'h0000_0F10, "R6 sll upper ignored");
    run_op(32'h8000_0000, 32'd4, 4'd5, 0, 32'h0800_0000, "R7 srl zero fill");
    run_op(32'hF000_0000, 32'd31, 4'd5, 0, 32'h0000_0001, "R7 srl 31");
    run_op(32'h8000_0000, 32'd4, 4'd6, 0, 32'hF800_0000, "R8 sra sign fill");
    run_op(32'h4000_0000, 32'd30, 4'd6, 0, 32'h0000_0001, "R8 sra positive");
    run_op(32'hA5A5_A5A5, 32'd0, 4'd6, 0, 32'hA5A5_A5A5, "R8 sra zero");
  endtask

  task automatic test_logic;
    run_op(32'hF0F0_1234, 32'hFF00_00FF, 4'd7, 0, 32'hF000_0034, "R9 and");
    run_op(32'hF0F0_1234, 32'hFF00_00FF, 4'd8, 0, 32'hFFF0_12FF, "R9 or");
    run_op(32'hF0F0_1234, 32'hFF00_00FF, 4'd9, 0, 32'h0FF0_12CB, "R9 xor");
    run_op(32'hF0F0_1234, 32'hFF00_00FF, 4'd10, 0, 32'h000F_ED00, "R9 nor");
  endtask

  task automatic test_swap_ignored;
    for (int op = 0; op <= 10; op++) begin
      if (op == 2 || op == 3) continue;
      run_op(32'h8765_4321, 32'h0000_0013, 4'(op), 1,
             model(32'h8765_4321, 32'h0000_0013, 4'(op), 0), "R10 swap ignored");
    end
  endtask

  task automatic test_unused;
    for (int op = 11; op <= 15; op++)
      run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(op), 1, 32'h0, "R11 unused code");
  endtask

  task automatic test_sweep;
    logic [W-1:0] a;
    logic [W-1:0] b;
    a = 32'h1357_9BDF;
    b = 32'h2468_ACE0;
    for (int k = 0; k < 40; k++) begin
      a = a * 32'd1103515245 + 32'd12345;
      b = b * 32'd22695477 + 32'd1;
      for (int op = 0; op <= 10; op++) begin
        run_op(a, b, 4'(op), k[0], model(a, b, 4'(op), k[0]),
               op <= 1 ? "R2 R3 sweep" : op <= 3 ? "R4 R5 sweep" :
               op <= 6 ? "R6 R7 R8 sweep" : "R9 sweep");
      end
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    test_add_sub();
    test_cmp_reg();
    test_cmp_imm();
    test_shifts();
    test_logic();
    test_swap_ignored();
    test_unused();
    test_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule